// File: doc/BRIEF.md
# Stage Delay-Test Mode Controller and Error Monitor

This block is the test-control hub for a pipeline of `NUM_STAGES` stages that each carry timing-error detectors. Every stage has one "slow test" bit that, when set, makes that stage sample later so a large path delay shows up as a flagged error. The bits are loaded one at a time through a serial chain (`chain_in` to `chain_out`) while `shift_en` is high, then copied to the stage outputs by an `update_en` strobe, so the stage bits never ripple while the chain moves. A `global_en` input forces every stage into test mode at once; that finds whether any stage has a fault, but not which one. Loading a single set bit at a time instead lets a diagnosis sequence locate the faulty stage, and bits may be left set in normal operation so that only the stages found faulty run slower.

The error bits of all stages are ORed into one line, `err_any`. While any stage is in test mode, each rising edge of that line is one detected delay fault: it increments a saturating counter, sets a sticky fault flag, and adds to a per-window event count. At the end of every window of `WIN_LEN` cycles the window count is published on `err_rate`; a rate that grows over the life of the part is read as an aging sign. `cnt_clr` synchronously clears the counter, the flag and the window.

The scan side is run by a state machine with states SC_HOLD (chain idle), SC_SHIFT (chain moving) and SC_APPLY (copy chain to stage bits). From any state the next state is SC_SHIFT when `shift_en` is high, SC_APPLY when `update_en` is high with `shift_en` low, and SC_HOLD otherwise. The error side tracks the OR line with states EM_LOW and EM_HIGH: EM_LOW goes to EM_HIGH when `err_any` is high (the rising-edge transition, the only one that counts), EM_HIGH goes back to EM_LOW when `err_any` is low.

Top module: `dtm_test_ctl`

## Requirements
- R1: `err_any` is the combinational OR of all bits of `stage_err`, with no clock delay.
- R2: While `global_en` is high, every bit of `stage_slow` is 1; while it is low, `stage_slow` equals the applied stage bits.
- R3: On each clock edge with `shift_en` high, the chain moves one place: `chain_in` enters bit `NUM_STAGES-1`, each bit i takes bit i+1, and `chain_out` shows bit 0; with `shift_en` low the chain holds. After `NUM_STAGES` shifts the first bit shifted in sits at stage 0.
- R4: The applied stage bits change only in SC_APPLY: `update_en` high with `shift_en` low at edge k moves the machine to SC_APPLY, and at edge k+1 the stage bits take the chain contents. `update_en` sampled together with `shift_en` high is ignored.
- R5: While test mode is active (any bit of `stage_slow` is 1), each rising edge of `err_any` increments `err_count` by one at the edge where `err_any` is first sampled high; a level held high for many cycles counts once.
- R6: A rising edge of `err_any` while every bit of `stage_slow` is 0 changes neither `err_count` nor `fault_seen`.
- R7: `err_count` saturates at all ones.
- R8: `cnt_clr` high at an edge sets `err_count`, `fault_seen`, `err_rate` and the window to zero at that edge, taking priority over counting.
- R9: `fault_seen` becomes 1 with the first counted event and stays 1 until `cnt_clr`.
- R10: The window restarts at `cnt_clr`; at every `WIN_LEN`-th edge after it, `err_rate` takes the number of events counted in the window just ended (saturating at all ones).
- R11: After reset, `stage_slow`, `chain_out`, `err_count`, `err_rate` and `fault_seen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| global_en | input | 1 | Force all stages into test mode |
| chain_in | input | 1 | Serial test-bit input |
| shift_en | input | 1 | Shift the chain by one place per cycle |
| update_en | input | 1 | Copy the chain to the stage bits |
| chain_out | output | 1 | Serial chain output (bit 0) |
| stage_err | input | NUM_STAGES | Rail-1 error bit of each stage |
| err_any | output | 1 | OR of all stage error bits |
| stage_slow | output | NUM_STAGES | Test-mode enable for each stage |
| cnt_clr | input | 1 | Synchronous clear of counter, flag and window |
| err_count | output | CNT_W | Saturating count of detected faults |
| fault_seen | output | 1 | Sticky detected-fault flag |
| err_rate | output | CNT_W | Events counted in the last complete window |

## Verification
The assertions check on every cycle that the chain and the stage bits hold when they should, that the counter never moves by more than one, stays still without test mode, holds at saturation and clears on `cnt_clr`, and that the fault flag is sticky. Only the bench's scenarios can show the bit ordering through the chain, that the stage bits match the pattern shifted in, that a held error level counts once, that forced global mode overrides loaded bits, and the number published per window.

// File: rtl/dtm_ctl_pkg.sv
package dtm_ctl_pkg;

    typedef enum logic [1:0] {
        SC_HOLD  = 2'd0,
        SC_SHIFT = 2'd1,
        SC_APPLY = 2'd2
    } scan_state_e;

    typedef enum logic {
        EM_LOW  = 1'b0,
        EM_HIGH = 1'b1
    } edge_state_e;

endpackage

// File: rtl/dtm_scan_chain.sv
module dtm_scan_chain
    import dtm_ctl_pkg::*;
#(
    parameter int NUM_STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chain_in,
    input  logic                  shift_en,
    input  logic                  update_en,
    output logic                  chain_out,
    output logic [NUM_STAGES-1:0] stage_q
);

    localparam int TOP = NUM_STAGES - 1;

    scan_state_e           state_q, state_d;
    logic [NUM_STAGES-1:0] chain_q;
    logic [NUM_STAGES-1:0] chain_d;
    logic                  apply_go;

    // next-state logic
    always_comb begin
        state_d = SC_HOLD;
        unique case (state_q)
            SC_HOLD, SC_SHIFT, SC_APPLY: begin
                if (shift_en)       state_d = SC_SHIFT;
                else if (update_en) state_d = SC_APPLY;
                else                state_d = SC_HOLD;
            end
            default: state_d = SC_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_HOLD;
        else        state_q <= state_d;
    end

    // outputs of the machine
    always_comb begin
        apply_go = 1'b0;
        unique case (state_q)
            SC_HOLD:  apply_go = 1'b0;
            SC_SHIFT: apply_go = 1'b0;
            SC_APPLY: apply_go = 1'b1;
            default:  apply_go = 1'b0;
        endcase
    end

    // shift path, one cell per stage
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_cell
        if (i == TOP) begin : g_head
            assign chain_d[i] = shift_en ? chain_in : chain_q[i];
        end else begin : g_body
            assign chain_d[i] = shift_en ? chain_q[i+1] : chain_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            stage_q <= '0;
        end else begin
            chain_q <= chain_d;
            if (apply_go) stage_q <= chain_q;
        end
    end

    assign chain_out = chain_q[0];

    assert_chain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q));

    assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SC_APPLY) |=> $stable(stage_q));

    assert_shift_blocks_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (state_q == SC_SHIFT));

endmodule

// File: rtl/dtm_err_monitor.sv
module dtm_err_monitor
    import dtm_ctl_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int CNT_W      = 16,
    parameter int WIN_LEN    = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STAGES-1:0] stage_err,
    input  logic [NUM_STAGES-1:0] stage_slow,
    input  logic                  cnt_clr,
    output logic                  err_any,
    output logic [CNT_W-1:0]      err_count,
    output logic                  fault_seen,
    output logic [CNT_W-1:0]      err_rate
);

    localparam int               WIN_W    = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    edge_state_e      edge_q, edge_d;
    logic             rise;
    logic             test_active;
    logic             hit;
    logic [WIN_W-1:0] win_pos;
    logic [CNT_W-1:0] win_ev;
    logic [CNT_W-1:0] win_total;

    assign err_any     = |stage_err;
    assign test_active = |stage_slow;

    // level tracker: next state
    always_comb begin
        edge_d = EM_LOW;
        unique case (edge_q)
            EM_LOW:  edge_d = err_any ? EM_HIGH : EM_LOW;
            EM_HIGH: edge_d = err_any ? EM_HIGH : EM_LOW;
            default: edge_d = EM_LOW;
        endcase
    end

    // level tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= EM_LOW;
        else        edge_q <= edge_d;
    end

    // level tracker: output
    always_comb begin
        rise = 1'b0;
        unique case (edge_q)
            EM_LOW:  rise = err_any;
            EM_HIGH: rise = 1'b0;
            default: rise = 1'b0;
        endcase
    end

    assign hit       = rise && test_active;
    assign win_total = (hit && (win_ev != CNT_MAX)) ? win_ev + CNT_W'(1) : win_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_count  <= '0;
            fault_seen <= 1'b0;
        end else if (cnt_clr) begin
            err_count  <= '0;
            fault_seen <= 1'b0;
        end else if (hit) begin
            fault_seen <= 1'b1;
            if (err_count != CNT_MAX) err_count <= err_count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_pos  <= '0;
            win_ev   <= '0;
            err_rate <= '0;
        end else if (cnt_clr) begin
            win_pos  <= '0;
            win_ev   <= '0;
            err_rate <= '0;
        end else if (win_pos == WIN_LAST) begin
            win_pos  <= '0;
            win_ev   <= '0;
            err_rate <= win_total;
        end else begin
            win_pos  <= win_pos + WIN_W'(1);
            win_ev   <= win_total;
        end
    end

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (err_count == $past(err_count)) ||
                     (err_count == $past(err_count) + CNT_W'(1)));

    assert_no_count_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !test_active) |=> $stable(err_count));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && err_count == CNT_MAX) |=> err_count == CNT_MAX);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (err_count == '0) && !fault_seen && (err_rate == '0));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_seen && !cnt_clr) |=> fault_seen);

    assert_flag_with_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != '0) |-> fault_seen);

endmodule

// File: rtl/dtm_test_ctl.sv
module dtm_test_ctl
    import dtm_ctl_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int CNT_W      = 16,
    parameter int WIN_LEN    = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  global_en,
    input  logic                  chain_in,
    input  logic                  shift_en,
    input  logic                  update_en,
    output logic                  chain_out,
    input  logic [NUM_STAGES-1:0] stage_err,
    output logic                  err_any,
    output logic [NUM_STAGES-1:0] stage_slow,
    input  logic                  cnt_clr,
    output logic [CNT_W-1:0]      err_count,
    output logic                  fault_seen,
    output logic [CNT_W-1:0]      err_rate
);

    logic [NUM_STAGES-1:0] applied_bits;

    dtm_scan_chain #(
        .NUM_STAGES (NUM_STAGES)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .chain_in  (chain_in),
        .shift_en  (shift_en),
        .update_en (update_en),
        .chain_out (chain_out),
        .stage_q   (applied_bits)
    );

    assign stage_slow = global_en ? '1 : applied_bits;

    dtm_err_monitor #(
        .NUM_STAGES (NUM_STAGES),
        .CNT_W      (CNT_W),
        .WIN_LEN    (WIN_LEN)
    ) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_err  (stage_err),
        .stage_slow (stage_slow),
        .cnt_clr    (cnt_clr),
        .err_any    (err_any),
        .err_count  (err_count),
        .fault_seen (fault_seen),
        .err_rate   (err_rate)
    );

endmodule

// File: tb/test_dtm_test_ctl.sv
module test_dtm_test_ctl;

    localparam int S  = 4;
    localparam int CW = 4;
    localparam int WL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          global_en = 1'b0;
    logic          chain_in = 1'b0;
    logic          shift_en = 1'b0;
    logic          update_en = 1'b0;
    logic          chain_out;
    logic [S-1:0]  stage_err = '0;
    logic          err_any;
    logic [S-1:0]  stage_slow;
    logic          cnt_clr = 1'b0;
    logic [CW-1:0] err_count;
    logic          fault_seen;
    logic [CW-1:0] err_rate;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dtm_test_ctl #(.NUM_STAGES(S), .CNT_W(CW), .WIN_LEN(WL)) i_dtm_test_ctl (
        .clk(clk), .rst_n(rst_n), .global_en(global_en), .chain_in(chain_in),
        .shift_en(shift_en), .update_en(update_en), .chain_out(chain_out),
        .stage_err(stage_err), .err_any(err_any), .stage_slow(stage_slow),
        .cnt_clr(cnt_clr), .err_count(err_count), .fault_seen(fault_seen),
        .err_rate(err_rate)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_bits(input logic [S-1:0] v);
        for (int i = 0; i < S; i++) begin
            chain_in = v[i];
            shift_en = 1'b1;
            cyc(1);
        end
        shift_en  = 1'b0;
        update_en = 1'b1;
        cyc(1);
        update_en = 1'b0;
        cyc(1);
    endtask

    task automatic pulse(input int idx);
        stage_err[idx] = 1'b1;
        cyc(1);
        stage_err[idx] = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset;
        chk("R11 stage_slow", 32'(stage_slow), 0);
        chk("R11 chain_out", 32'(chain_out), 0);
        chk("R11 err_count", 32'(err_count), 0);
        chk("R11 err_rate", 32'(err_rate), 0);
        chk("R11 fault_seen", 32'(fault_seen), 0);
    endtask

    task automatic t_or;
        for (int i = 0; i < S; i++) begin
            stage_err = S'(1) << i;
            #1 chk("R1 one-hot", 32'(err_any), 1);
        end
        stage_err = '0;
        #1 chk("R1 none", 32'(err_any), 0);
        stage_err = '1;
        #1 chk("R1 all", 32'(err_any), 1);
        stage_err = '0;
        cyc(1);
        // no stage in test mode: an edge must not count
        pulse(2);
        chk("R6 idle count", 32'(err_count), 0);
        chk("R6 idle flag", 32'(fault_seen), 0);
    endtask

    task automatic t_scan;
        logic [S-1:0] v = 4'b1010;
        for (int i = 0; i < S; i++) begin
            chain_in = v[i];
            shift_en = 1'b1;
            cyc(1);
        end
        shift_en = 1'b0;
        chk("R4 no apply after shift", 32'(stage_slow), 0);
        chk("R3 chain_out bit0", 32'(chain_out), 32'(v[0]));
        chain_in = 1'b1;
        cyc(3);
        chk("R3 hold", 32'(chain_out), 32'(v[0]));
        update_en = 1'b1;
        cyc(1);
        update_en = 1'b0;
        chk("R4 one-cycle latency", 32'(stage_slow), 0);
        cyc(1);
        chk("R4 applied", 32'(stage_slow), 32'(v));
        chain_in = 1'b1;
        shift_en = 1'b1;
        cyc(1);
        shift_en = 1'b0;
        chk("R3 next bit out", 32'(chain_out), 32'(v[1]));
        // update together with shift: ignored
        shift_en  = 1'b1;
        update_en = 1'b1;
        chain_in  = 1'b0;
        cyc(1);
        shift_en  = 1'b0;
        update_en = 1'b0;
        cyc(2);
        chk("R4 update during shift ignored", 32'(stage_slow), 32'(v));
    endtask

    task automatic t_global;
        global_en = 1'b1;
        #1 chk("R2 forced", 32'(stage_slow), 32'hF);
        global_en = 1'b0;
        #1 chk("R2 released", 32'(stage_slow), 32'hA);
        cyc(1);
    endtask

    task automatic t_count;
        cnt_clr = 1'b1;
        cyc(1);
        cnt_clr = 1'b0;
        stage_err[1] = 1'b1;
        cyc(3);
        chk("R5 held level counts once", 32'(err_count), 1);
        chk("R9 flag set", 32'(fault_seen), 1);
        stage_err[1] = 1'b0;
        cyc(1);
        stage_err = 4'b0011;
        cyc(1);
        stage_err = 4'b0001;
        cyc(1);
        stage_err = '0;
        cyc(1);
        chk("R5 second edge", 32'(err_count), 2);
        load_bits('0);
        chk("R2 bits cleared", 32'(stage_slow), 0);
        pulse(3);
        chk("R6 no test mode", 32'(err_count), 2);
        chk("R9 flag still set", 32'(fault_seen), 1);
    endtask

    task automatic t_sat;
        global_en = 1'b1;
        for (int i = 0; i < 20; i++) pulse(i % S);
        chk("R7 saturates", 32'(err_count), 32'hF);
        cnt_clr = 1'b1;
        cyc(1);
        cnt_clr = 1'b0;
        chk("R8 count cleared", 32'(err_count), 0);
        chk("R8 flag cleared", 32'(fault_seen), 0);
        global_en = 1'b0;
    endtask

    task automatic t_rate;
        global_en = 1'b1;
        cnt_clr   = 1'b1;
        cyc(1);
        cnt_clr = 1'b0;
        pulse(0);
        pulse(1);
        pulse(2);
        cyc(14);
        chk("R10 rate of window", 32'(err_rate), 3);
        cyc(16);
        chk("R10 empty window", 32'(err_rate), 0);
        global_en = 1'b0;
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_or();
        t_scan();
        t_global();
        t_count();
        t_sat();
        t_rate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule